// File: doc/BRIEF.md
# 10 Mb/s Transmit Jabber Guard and Heartbeat Generator

This block supervises the transmit enable of a 10 Mb/s Ethernet port. When a station keeps its transmit enable asserted without a break for longer than a fixed limit, the block declares jabber. It then blocks the enable it passes downstream until the line has stayed quiet for a separate, longer release interval. A sticky status bit records every jabber event until software acknowledges it with a one-cycle clear strobe.

The block also produces the signal quality test (heartbeat) pulse on the collision output. After each frame ends, it waits a fixed delay and then holds the collision output high for a fixed length. The pulse is skipped when heartbeat is disabled, and also after a frame that was cut off by jabber. Both functions are active only while the port runs at 10 Mb/s. At any other speed the transmit enable passes straight through, and the lockout and any pending pulse are dropped.

All intervals are parameters counted in clock cycles. The defaults match 85 ms, 500 ms, 1200 ns and 1000 ns at a 125 MHz clock.

Top module: `sqe_jabber_guard`

## Requirements
- R1: After reset, `tx_en_o`, `jab_lock_o`, `jab_seen_o` and `col_o` are all 0 while `tx_en_i` is 0.
- R2: While `mode_10m_i` is 0, `tx_en_o` equals `tx_en_i`, no lockout is declared (`jab_lock_o` is 0 from the next cycle) and `col_o` stays 0.
- R3: In 10 Mb/s mode, jabber is declared at the clock edge that samples `tx_en_i` high for the `JAB_CYC`-th consecutive time. From that edge, `jab_lock_o` is 1 and `tx_en_o` is 0.
- R4: A burst of exactly `JAB_CYC`-1 high samples is passed in full and declares no jabber.
- R5: The lockout ends at the edge that samples `tx_en_i` low for the `REL_CYC`-th consecutive time. A high sample during the lockout restarts this count.
- R6: While `jab_lock_o` is 1 in 10 Mb/s mode, `tx_en_o` is 0 whatever the value of `tx_en_i`.
- R7: `jab_seen_o` becomes 1 with each declaration and stays 1 until a cycle in which `jab_clr_i` is 1. A declaration in that same cycle wins, and the bit stays 1.
- R8: When a sample shows `tx_en_i` low after a high sample (the frame end edge), `col_o` rises `HB_DLY_CYC` edges later and stays 1 for `HB_LEN_CYC` cycles.
- R9: No pulse follows a frame end edge at which `hb_en_i` is 0.
- R10: No pulse follows a frame end edge at which the lockout is active.
- R11: A frame end edge that arrives while a pulse is still waiting or running is ignored. Leaving 10 Mb/s mode cancels a pending or running pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| mode_10m_i | input | 1 | 1 when the port runs at 10 Mb/s |
| hb_en_i | input | 1 | Heartbeat enable |
| jab_clr_i | input | 1 | Clear strobe for the jabber status bit |
| tx_en_o | output | 1 | Transmit enable after jabber gating |
| jab_lock_o | output | 1 | Jabber lockout active |
| jab_seen_o | output | 1 | Sticky jabber status |
| col_o | output | 1 | Heartbeat pulse on the collision output |

## Verification
The two functions that can land on the same edge are a new jabber declaration and the status clear strobe. The bench raises `jab_clr_i` for exactly the cycle whose edge samples the `JAB_CYC`-th high transmit enable, and expects `jab_seen_o` to stay 1 afterwards. A second overlap is a frame end that meets an active lockout. The bench ends a jabbered frame and checks that the heartbeat stays silent. A cycle-accurate reference model compares every output on every clock throughout.

// File: rtl/jabhb_pkg.sv
package jabhb_pkg;

    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_WAIT  = 2'd1,
        HB_PULSE = 2'd2
    } hb_state_e;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/jabber_lockout.sv
module jabber_lockout #(
    parameter int JAB_CYC = 10_625_000,
    parameter int REL_CYC = 62_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    input  logic mode_i,
    input  logic clr_i,
    output logic lock_o,
    output logic sticky_o
);
    import jabhb_pkg::*;

    localparam int RUN_W = cnt_width(JAB_CYC);
    localparam int REL_W = cnt_width(REL_CYC);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(JAB_CYC - 1);
    localparam logic [REL_W-1:0] REL_LAST = REL_W'(REL_CYC - 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic [REL_W-1:0] rel;
        logic             lock;
        logic             sticky;
    } jab_st_t;

    jab_st_t st_d, st_q;
    logic    declare;

    always_comb begin
        st_d    = st_q;
        declare = 1'b0;
        if (!mode_i) begin
            st_d.run  = '0;
            st_d.rel  = '0;
            st_d.lock = 1'b0;
        end else if (!st_q.lock) begin
            if (tx_en_i) begin
                if (st_q.run == RUN_LAST) begin
                    declare   = 1'b1;
                    st_d.lock = 1'b1;
                    st_d.run  = '0;
                    st_d.rel  = '0;
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.run = '0;
            end
        end else begin
            if (tx_en_i) begin
                st_d.rel = '0;
            end else if (st_q.rel == REL_LAST) begin
                st_d.lock = 1'b0;
                st_d.rel  = '0;
            end else begin
                st_d.rel = st_q.rel + 1'b1;
            end
        end
        if (declare) begin
            st_d.sticky = 1'b1;
        end else if (clr_i) begin
            st_d.sticky = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o   = st_q.lock;
    assign sticky_o = st_q.sticky;

    // R3: a lockout only starts on an edge that sampled transmit enable high
    a_r3_declare_on_tx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lock) |-> $past(tx_en_i));

    // R5: a lockout ends in 10 Mb/s mode only after a quiet sample
    a_r5_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.lock) && $past(mode_i)) |-> !$past(tx_en_i));

    // R2: outside 10 Mb/s mode no lockout survives the next edge
    a_r2_no_lock_fast: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |=> !st_q.lock);

    // R7: status drops only after a clear strobe
    a_r7_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.sticky) |-> $past(clr_i));

    // R7: each new lockout leaves the status set
    a_r7_set_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lock) |-> st_q.sticky);

endmodule

// File: rtl/heartbeat_gen.sv
module heartbeat_gen #(
    parameter int DLY_CYC = 150,
    parameter int LEN_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    input  logic mode_i,
    input  logic hb_en_i,
    input  logic lock_i,
    output logic col_o
);
    import jabhb_pkg::*;

    localparam int MAXC  = (DLY_CYC > LEN_CYC) ? DLY_CYC : LEN_CYC;
    localparam int CNT_W = cnt_width(MAXC);
    localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DLY_CYC - 1);
    localparam logic [CNT_W-1:0] LEN_LAST = CNT_W'(LEN_CYC - 1);

    typedef struct packed {
        hb_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             prev_tx;
    } hb_st_t;

    hb_st_t st_d, st_q;
    logic   frame_end;

    always_comb begin
        st_d         = st_q;
        st_d.prev_tx = tx_en_i;
        frame_end    = st_q.prev_tx && !tx_en_i;
        if (!mode_i) begin
            st_d.state = HB_IDLE;
            st_d.cnt   = '0;
        end else begin
            unique case (st_q.state)
                HB_IDLE: begin
                    if (frame_end && hb_en_i && !lock_i) begin
                        st_d.state = HB_WAIT;
                        st_d.cnt   = '0;
                    end
                end
                HB_WAIT: begin
                    if (st_q.cnt == DLY_LAST) begin
                        st_d.state = HB_PULSE;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                HB_PULSE: begin
                    if (st_q.cnt == LEN_LAST) begin
                        st_d.state = HB_IDLE;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: begin
                    st_d.state = HB_IDLE;
                    st_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: HB_IDLE, cnt: '0, prev_tx: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o = (st_q.state == HB_PULSE);

    // R10: a delay phase never begins on an edge where the lockout was active
    a_r10_no_hb_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == HB_WAIT && $past(st_q.state) == HB_IDLE) |-> !$past(lock_i));

    // R9: a delay phase never begins with heartbeat disabled
    a_r9_no_hb_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == HB_WAIT && $past(st_q.state) == HB_IDLE) |-> $past(hb_en_i));

    // R8: the pulse is always preceded by the delay phase
    a_r8_pulse_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_o) |-> $past(st_q.state) == HB_WAIT);

    // R11: leaving 10 Mb/s mode silences the collision output
    a_r11_abort_fast: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |=> !col_o);

endmodule

// File: rtl/sqe_jabber_guard.sv
module sqe_jabber_guard #(
    parameter int JAB_CYC    = 10_625_000,
    parameter int REL_CYC    = 62_500_000,
    parameter int HB_DLY_CYC = 150,
    parameter int HB_LEN_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    input  logic mode_10m_i,
    input  logic hb_en_i,
    input  logic jab_clr_i,
    output logic tx_en_o,
    output logic jab_lock_o,
    output logic jab_seen_o,
    output logic col_o
);

    logic lock;

    jabber_lockout #(
        .JAB_CYC (JAB_CYC),
        .REL_CYC (REL_CYC)
    ) u_jab (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en_i  (tx_en_i),
        .mode_i   (mode_10m_i),
        .clr_i    (jab_clr_i),
        .lock_o   (lock),
        .sticky_o (jab_seen_o)
    );

    heartbeat_gen #(
        .DLY_CYC (HB_DLY_CYC),
        .LEN_CYC (HB_LEN_CYC)
    ) u_hb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en_i (tx_en_i),
        .mode_i  (mode_10m_i),
        .hb_en_i (hb_en_i),
        .lock_i  (lock),
        .col_o   (col_o)
    );

    assign tx_en_o    = tx_en_i & ~(lock & mode_10m_i);
    assign jab_lock_o = lock;

    // R6: gated enable is low whenever the lockout holds in 10 Mb/s mode
    a_r6_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (jab_lock_o && mode_10m_i) |-> !tx_en_o);

    // R2: outside 10 Mb/s mode the enable passes unchanged
    a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_10m_i |-> (tx_en_o == tx_en_i));

endmodule

// File: tb/tb_sqe_jabber_guard.sv
module tb_sqe_jabber_guard;

    localparam int J = 40;
    localparam int R = 60;
    localparam int D = 6;
    localparam int L = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx = 1'b0, mode = 1'b0, hb = 1'b0, clr = 1'b0;
    logic tx_o, lock_o, seen_o, col_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;
    string cur_req = "R1";

    // reference model state
    int  m_run, m_rel, m_age;
    bit  m_lock, m_seen, m_prev;

    always #4 clk = ~clk;

    sqe_jabber_guard #(
        .JAB_CYC (J), .REL_CYC (R), .HB_DLY_CYC (D), .HB_LEN_CYC (L)
    ) dut (
        .clk (clk), .rst_n (rst_n), .tx_en_i (tx), .mode_10m_i (mode),
        .hb_en_i (hb), .jab_clr_i (clr), .tx_en_o (tx_o),
        .jab_lock_o (lock_o), .jab_seen_o (seen_o), .col_o (col_o)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %0b expected %0b", req, what, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit fall, declare;
        if (!rst_n) begin
            m_run = 0; m_rel = 0; m_age = -1;
            m_lock = 0; m_seen = 0; m_prev = 0;
        end else begin
            fall = m_prev && !tx;
            declare = 0;
            if (!mode) m_age = -1;
            else if (m_age >= 0) begin
                m_age++;
                if (m_age == D + L) m_age = -1;
            end else if (fall && hb && !m_lock) m_age = 0;
            if (!mode) begin
                m_run = 0; m_rel = 0; m_lock = 0;
            end else if (!m_lock) begin
                if (tx) begin
                    m_run++;
                    if (m_run == J) begin
                        m_lock = 1; m_run = 0; m_rel = 0; declare = 1;
                    end
                end else m_run = 0;
            end else begin
                if (tx) m_rel = 0;
                else begin
                    m_rel++;
                    if (m_rel == R) begin m_lock = 0; m_rel = 0; end
                end
            end
            if (declare) m_seen = 1;
            else if (clr) m_seen = 0;
            m_prev = tx;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n && !done) begin
            chk(cur_req, "tx_en_o", tx_o, tx & !(m_lock & mode));
            chk(cur_req, "jab_lock_o", lock_o, m_lock);
            chk(cur_req, "jab_seen_o", seen_o, m_seen);
            chk(cur_req, "col_o", col_o, (m_age >= D));
        end
    end

    task automatic hold(logic v, int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; tx = v;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int col_cnt;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "tx_en_o", tx_o, 1'b0);
        chk("R1", "jab_lock_o", lock_o, 1'b0);
        chk("R1", "jab_seen_o", seen_o, 1'b0);
        chk("R1", "col_o", col_o, 1'b0);
        cmp_on = 1'b1;

        // R2: fast mode, long burst passes untouched
        cur_req = "R2";
        hold(1, J + 60); hold(0, 20);
        chk("R2", "jab_seen_o after long fast burst", seen_o, 1'b0);

        // R8: short frame then heartbeat, count pulse width
        @(posedge clk); #1 mode = 1'b1; hb = 1'b1;
        cur_req = "R8";
        hold(1, 10);
        @(posedge clk); #1 tx = 1'b0;
        col_cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (col_o) col_cnt++;
        end
        chk("R8", "heartbeat length", (col_cnt == L), 1'b1);

        // R4: burst one short of the limit passes, heartbeat follows
        cur_req = "R4";
        hold(1, J - 1); hold(0, 30);
        chk("R4", "jab_seen_o after J-1 burst", seen_o, 1'b0);

        // R3 R6 R10: jabber, blocked, no heartbeat after the cut frame
        cur_req = "R3_R6_R10";
        hold(1, J + 20); hold(0, 10);
        cur_req = "R5";
        hold(1, 5); hold(0, R + 5);
        chk("R5", "jab_lock_o released", lock_o, 1'b0);

        // R7: plain clear
        cur_req = "R7";
        @(posedge clk); #1 clr = 1'b1;
        @(posedge clk); #1 clr = 1'b0;
        @(negedge clk);
        chk("R7", "jab_seen_o after clear", seen_o, 1'b0);

        // R7: clear strobe on the declaring edge, set wins
        hold(1, J - 1);
        @(posedge clk); #1 clr = 1'b1;
        @(posedge clk); #1 clr = 1'b0;
        @(negedge clk);
        chk("R7", "jab_seen_o set beats clear", seen_o, 1'b1);
        hold(1, 5); hold(0, R + 5);

        // R9: heartbeat disabled
        cur_req = "R9";
        @(posedge clk); #1 hb = 1'b0;
        col_cnt = 0;
        hold(1, 10);
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #1 tx = 1'b0;
            @(negedge clk);
            if (col_o) col_cnt++;
        end
        chk("R9", "no pulse with heartbeat off", (col_cnt == 0), 1'b1);
        @(posedge clk); #1 hb = 1'b1;

        // R11: second frame end during pulse ignored, mode drop cancels
        cur_req = "R11";
        hold(1, 3); hold(0, 2); hold(1, 3); hold(0, 30);
        hold(1, 5); hold(0, D + 1);
        @(posedge clk); #1 mode = 1'b0;
        hold(0, 10);
        @(posedge clk); #1 mode = 1'b1;
        hold(0, 20);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule